// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

A 16-bit up-counter drives a bank of four channel registers. Each channel works either as a compare register or as a capture register. A compare channel raises a one-cycle match pulse when the counter reaches its value. A capture channel stores the running count when its trigger input rises. An 8-bit option register holds the per-channel capture/compare select bits and a sticky overflow flag. The block also drives a single-cycle overflow interrupt.

The counter stays at zero while the enable input is low. Once enabled it advances by one each clock and wraps from 0xFFFF to 0x0000. A 2-bit mode input sets how the block behaves. Code 0 is free-running and is the only mode in which the capture selects apply. Code 1 is pulse-width measurement. Codes 2 and 3 are other timer modes, and in them overflow is not reported. Software reaches the option register, the counter and the four channel registers through a simple register port. Writes take effect on the clock edge and reads are combinational.

Top module: `fr_cc_timer`

## Requirements
- R1: While `cnt_en` is 0 the counter holds 0x0000. While it is 1 the counter rises by one per clock and wraps from 0xFFFF to 0x0000. The count reads back at address 1, and writes to address 1 are ignored.
- R2: The option register sits at address 0, is 8 bits wide and resets to 0x00. Bit 4+m is the select bit of channel m (0 = compare, 1 = capture), bits 3..1 always read 0, and bit 0 is the overflow flag.
- R3: The overflow flag sets on the clock edge where the counter wraps from 0xFFFF to 0x0000, and only in mode 0 or mode 1. A wrap in mode 2 or 3 leaves the flag at 0.
- R4: `ovf_irq` is high for exactly the one cycle in which the flag becomes set. It never pulses in mode 2 or 3.
- R5: Reading the option register does not clear the flag. Writing 1 to bit 0 has no effect.
- R6: The flag clears when software writes 0 to bit 0 of address 0, or on any clock edge where `cnt_en` is 0.
- R7: A write to address 0 updates the select bits only while `cnt_en` is 0. While the counter runs, such a write leaves the select bits unchanged.
- R8: A select bit of 1 makes its channel capture only in mode 0. In modes 1 to 3 every channel acts as a compare channel, and its trigger input is ignored.
- R9: A compare channel drives `cmp_match[m]` high for one cycle, in the cycle after the enabled counter equals its register. A capture channel never drives a match.
- R10: Channel m is read and written at address 4+m. A rising edge on `cap_trig[m]` of a capture channel stores the count seen at that clock edge. A trigger held high does not capture again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable; 0 holds the count at zero and clears the flag |
| mode | input | 2 | 0 free-running, 1 pulse-width measurement, 2/3 other |
| cap_trig | input | 4 | Per-channel capture triggers, rising edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 option, 1 counter, 4..7 channels |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cmp_match | output | 4 | Per-channel compare match pulses |
| ovf_irq | output | 1 | Overflow interrupt pulse |

## Verification
The bench runs the counter through three full wraps, one each in free-running, another mode and pulse-width mode. A design that reported overflow in every mode, or that missed it in pulse-width mode, therefore fails. After the flag sets, the bench reads it twice, writes 1 to it, then writes 0. A flag that clears on read, or that accepts a 1 from software, shows up there. The bench also attempts a select change while the counter runs, holds a trigger high across several clocks, and fires a trigger on a capture-selected channel outside free-running mode. Each case catches a different fault: selects that are not locked, level-sensitive capture, or capture that ignores the mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      TMR_FREERUN = 2'd0,
      TMR_PULSEW  = 2'd1,
      TMR_OTHER_A = 2'd2,
      TMR_OTHER_B = 2'd3
   } tmr_mode_e;

   // overflow is reported only in these two modes
   function automatic logic mode_reports_ovf(input tmr_mode_e m);
      return (m == TMR_FREERUN) || (m == TMR_PULSEW);
   endfunction

   // capture selects apply only while free-running
   function automatic logic mode_allows_capture(input tmr_mode_e m);
      return (m == TMR_FREERUN);
   endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("tmr_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!cnt_en) cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   // this edge takes the count from all ones back to zero
   assign wrap = cnt_en && (cnt == CNT_MAX);

   p_hold_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> (cnt == '0));

   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/tmr_option_reg.sv
module tmr_option_reg
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  tmr_mode_e         mode,
   input  logic              wr_opt,
   input  logic [7:0]        wdata,
   input  logic              wrap,
   output logic [NUM_CH-1:0] sel,
   output logic              ovf_flag,
   output logic              ovf_irq,
   output logic [7:0]        opt_byte
);

   localparam int SEL_LSB = 4;
   localparam int OVF_BIT = 0;

   if (NUM_CH < 1 || SEL_LSB + NUM_CH > 8) begin : g_bad_ch
      $error("tmr_option_reg: select bits must fit in bits 7..4");
   end

   logic set_evt;
   assign set_evt = wrap && mode_reports_ovf(mode);

   // select bits: writable only while the counter is stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sel <= '0;
      else if (wr_opt && !cnt_en) sel <= wdata[SEL_LSB +: NUM_CH];
   end

   // sticky flag: set by a reported wrap, cleared by a written 0 or by disable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ovf_flag <= 1'b0;
      else if (!cnt_en)                   ovf_flag <= 1'b0;
      else if (set_evt)                   ovf_flag <= 1'b1;
      else if (wr_opt && !wdata[OVF_BIT]) ovf_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_irq <= 1'b0;
      else        ovf_irq <= set_evt && !ovf_flag;
   end

   always_comb begin
      opt_byte = '0;
      opt_byte[SEL_LSB +: NUM_CH] = sel;
      opt_byte[OVF_BIT] = ovf_flag;
   end

   p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && mode_reports_ovf(mode)) |=> ovf_flag);

   p_ovf_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(wrap && mode_reports_ovf(mode)));

   p_irq_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ovf_irq);

   p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |=> !ovf_irq);

   p_flag_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> !ovf_flag);

   p_write_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag && wr_opt && wdata[OVF_BIT] && !wrap) |=> !ovf_flag);

   p_sel_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> $stable(sel));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             cap_mode,
   input  logic             trig,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] ccr,
   output logic             match
);

   logic trig_q;
   logic trig_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= trig;
   end

   assign trig_rise = trig && !trig_q;

   // a capture event takes priority over a software write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ccr <= '0;
      else if (cap_mode && trig_rise) ccr <= cnt;
      else if (wr)                    ccr <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match <= 1'b0;
      else        match <= cnt_en && !cap_mode && (cnt == ccr);
   end

   p_match_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> !match);

   p_cap_no_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mode |=> !match);

   p_cap_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_mode && trig_rise) |=> (ccr == $past(cnt)));

   p_no_cap_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_mode && !wr) |=> $stable(ccr));

endmodule

// File: rtl/fr_cc_timer.sv
module fr_cc_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 4,
   parameter int DATA_W = 16,
   parameter int REG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic [1:0]        mode,
   input  logic [NUM_CH-1:0] cap_trig,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] cmp_match,
   output logic              ovf_irq
);

   localparam int OPT_ADDR = 0;
   localparam int CNT_ADDR = 1;
   localparam int CH_BASE  = 4;

   if (CNT_W > DATA_W) begin : g_bad_data
      $error("fr_cc_timer: CNT_W must not exceed DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_opt
      $error("fr_cc_timer: DATA_W must hold the 8-bit option register");
   end
   if (CH_BASE + NUM_CH > (1 << REG_AW)) begin : g_bad_map
      $error("fr_cc_timer: channel addresses exceed the address space");
   end

   tmr_mode_e         mode_e;
   logic [CNT_W-1:0]  cnt;
   logic              wrap;
   logic              wr_opt;
   logic [NUM_CH-1:0] sel;
   logic [NUM_CH-1:0] cap_eff;
   logic              ovf_flag;
   logic [7:0]        opt_byte;
   logic [CNT_W-1:0]  ccr [NUM_CH];

   assign mode_e = tmr_mode_e'(mode);
   assign wr_opt = reg_wr && (reg_addr == REG_AW'(OPT_ADDR));

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_en (cnt_en),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   tmr_option_reg #(.NUM_CH(NUM_CH)) u_opt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_en   (cnt_en),
      .mode     (mode_e),
      .wr_opt   (wr_opt),
      .wdata    (reg_wdata[7:0]),
      .wrap     (wrap),
      .sel      (sel),
      .ovf_flag (ovf_flag),
      .ovf_irq  (ovf_irq),
      .opt_byte (opt_byte)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic ch_wr;
      assign ch_wr      = reg_wr && (reg_addr == REG_AW'(CH_BASE + i));
      assign cap_eff[i] = sel[i] && mode_allows_capture(mode_e);

      tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .cnt_en   (cnt_en),
         .cap_mode (cap_eff[i]),
         .trig     (cap_trig[i]),
         .cnt      (cnt),
         .wr       (ch_wr),
         .wdata    (reg_wdata[CNT_W-1:0]),
         .ccr      (ccr[i]),
         .match    (cmp_match[i])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(OPT_ADDR)) reg_rdata[7:0] = opt_byte;
      if (reg_addr == REG_AW'(CNT_ADDR)) reg_rdata[CNT_W-1:0] = cnt;
      for (int k = 0; k < NUM_CH; k++) begin
         if (reg_addr == REG_AW'(CH_BASE + k)) reg_rdata[CNT_W-1:0] = ccr[k];
      end
   end

   p_match_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> (cmp_match == '0));

   p_irq_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_reports_ovf(mode_e) |=> !ovf_irq);

   p_rst_opt_r2: assert property (@(posedge clk)
      !rst_n |-> (opt_byte == 8'h00));

endmodule

// File: tb/fr_cc_timer_tb.sv
module fr_cc_timer_tb;

   localparam int W = 16;
   localparam logic [1:0] M_FREE = 2'd0, M_PW = 2'd1, M_OTHER = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic [1:0]  mode = M_FREE;
   logic [3:0]  cap_trig = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  cmp_match;
   logic        ovf_irq;

   int n_chk = 0;
   int n_err = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   // bench model built from the requirements
   logic [W-1:0] model_cnt = '0;
   logic [W-1:0] model_ccr [4];
   logic [3:0]   sh_sel = '0;
   logic [3:0]   exp_match = '0;
   logic         exp_irq = 1'b0;

   typedef struct { int ch; logic [W-1:0] val; } cap_item_t;
   cap_item_t cap_q [$];

   always #4 clk = ~clk;   // 125 MHz

   fr_cc_timer u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
      .cap_trig(cap_trig), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cmp_match(cmp_match), .ovf_irq(ovf_irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_cnt <= '0; exp_match <= '0; exp_irq <= 1'b0;
      end else begin
         for (int i = 0; i < 4; i++)
            exp_match[i] <= cnt_en && !(sh_sel[i] && mode == M_FREE) && (model_cnt == model_ccr[i]);
         exp_irq   <= cnt_en && (model_cnt == 16'hFFFF) && (mode == M_FREE || mode == M_PW);
         model_cnt <= cnt_en ? model_cnt + 1'b1 : '0;
      end
   end

   // monitor: match and interrupt pulses against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (cmp_match !== exp_match) check("R9 match pulses", {12'h0, cmp_match}, {12'h0, exp_match});
         else if (cmp_match != 0) n_chk++;
         if (ovf_irq !== exp_irq) check("R4 overflow irq", {15'h0, ovf_irq}, {15'h0, exp_irq});
         else if (ovf_irq) n_chk++;
         if (ovf_irq) irq_seen++;
      end
   end

   task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      if (a == 3'd0 && !cnt_en) sh_sel = d[7:4];
      if (a >= 3'd4) model_ccr[a - 3'd4] = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk); reg_addr = a; #1 v = reg_rdata;
   endtask

   // driver: fire a trigger and push the expected capture into the scoreboard
   task automatic fire_trig(input int ch, input bit captures, input int hold);
      cap_item_t it;
      @(negedge clk);
      it.ch = ch; it.val = model_cnt;
      cap_trig[ch] = 1'b1;
      @(posedge clk); #1;
      if (captures) begin model_ccr[ch] = it.val; cap_q.push_back(it); end
      repeat (hold) @(negedge clk);
      cap_trig[ch] = 1'b0;
   endtask

   task automatic pop_capture(input string req);
      cap_item_t it;
      logic [15:0] v;
      if (cap_q.size() == 0) begin check({req, " scoreboard empty"}, 16'h1, 16'h0); return; end
      it = cap_q.pop_front();
      reg_read(3'(4 + it.ch), v);
      check(req, v, it.val);
   endtask

   task automatic wait_cnt(input logic [W-1:0] v);
      while (model_cnt != v) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) model_ccr[i] = '0;
      repeat (199_900) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      reg_read(3'd0, v); check("R2 option reset", v, 16'h0000);
      reg_read(3'd1, v); check("R1 counter reset", v, 16'h0000);
      check("R9 no match at reset", {12'h0, cmp_match}, 16'h0);

      // ch0, ch2 capture; reserved bits and bit0 written 1
      reg_write(3'd0, 16'h005F);
      reg_read(3'd0, v); check("R2 reserved read 0 / R7 sel written / R5 write one", v, 16'h0050);
      reg_write(3'd4, 16'h1234);
      reg_write(3'd5, 16'd100);
      reg_write(3'd6, 16'd7);
      reg_write(3'd7, 16'd200);
      reg_write(3'd1, 16'h4444);
      reg_read(3'd5, v); check("R10 channel write", v, 16'd100);
      repeat (5) @(negedge clk);
      reg_read(3'd1, v); check("R1 hold while disabled, addr1 write ignored", v, 16'h0000);

      mode = M_FREE; cnt_en = 1'b1;
      repeat (9) @(negedge clk);
      reg_read(3'd1, v); check("R1 count up", v, 16'd10);

      reg_write(3'd0, 16'h0030);
      reg_read(3'd0, v); check("R7 sel locked while enabled", v, 16'h0050);
      reg_write(3'd0, 16'h0050);
      reg_read(3'd0, v); check("R7 same value rewrite", v, 16'h0050);

      fire_trig(0, 1'b1, 4);
      pop_capture("R10 capture ch0, held trigger once");
      fire_trig(2, 1'b1, 1);
      pop_capture("R10 capture ch2");
      fire_trig(1, 1'b0, 1);
      reg_read(3'd5, v); check("R10 compare channel ignores trigger", v, 16'd100);

      wait_cnt(16'hFFFF);
      reg_read(3'd0, v); check("R3 flag after free-running wrap", v, 16'h0051);
      reg_read(3'd0, v); check("R5 read does not clear", v, 16'h0051);
      reg_write(3'd0, 16'h0051);
      reg_read(3'd0, v); check("R5 write one keeps flag", v, 16'h0051);
      reg_write(3'd0, 16'h0050);
      reg_read(3'd0, v); check("R6 write zero clears", v, 16'h0050);

      mode = M_OTHER;
      fire_trig(0, 1'b0, 1);
      reg_read(3'd4, v); check("R8 capture off outside free-running", v, model_ccr[0]);
      wait_cnt(16'hFFFF);
      reg_read(3'd0, v); check("R3 no flag in other mode", v, 16'h0050);

      mode = M_PW;
      wait_cnt(16'hFFFF);
      reg_read(3'd0, v); check("R3 flag after pulse-width wrap", v, 16'h0051);

      @(negedge clk); cnt_en = 1'b0;
      reg_read(3'd0, v); check("R6 disable clears flag", v, 16'h0050);
      reg_read(3'd1, v); check("R1 disable zeroes counter", v, 16'h0000);
      check("R4 irq count", 16'(irq_seen), 16'd2);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule